// File: doc/BRIEF.md
# Addressed Packet Receive Framer

This block takes bytes delivered one at a time by a serial byte receiver and assembles them into a single addressed packet in a local buffer. After a start request, the first byte is taken as the destination address. It is then filtered against the node's own address and the all-ones broadcast value. The second byte is a payload length, which is checked against a limit supplied at run time. After that, exactly length plus one bytes follow: the payload and a trailing checksum. Each byte that is kept appears on a buffer write port, at an address that starts at zero for every attempt and rises by one per byte.

Each attempt ends with a one-cycle completion pulse. A success flag and a two-bit result code are held until the next start. The code separates three cases: a packet addressed elsewhere, a byte-level receive fault, and an oversize length. The checksum byte is stored but not verified. Retries and consumers of the buffer sit outside the block. A build-time parameter switches off address filtering, so that every destination is accepted.

Top module: `rx_packet_framer`

## Requirements
- R1: A `start` pulse while the framer is idle arms it: `busy` rises on the next cycle, `ok` clears, `err_code` returns to 0 and the next stored byte goes to write address 0. A `start` while `busy` is high has no effect on the attempt in progress.
- R2: With filtering enabled, the first byte is accepted when it equals `own_addr` or 0xFF, and it is then written at address 0. Any other value writes nothing and ends the attempt with `err_code` 1 (not addressed to this node).
- R3: With parameter `ADDR_FILTER` set to 0, any first byte is accepted and written at address 0.
- R4: The second byte (the length) is always written at address 1. If it is greater than or equal to `max_len`, the attempt ends with `err_code` 3 (length error) and no further byte is taken.
- R5: When the length is valid, exactly length+1 further bytes are written at consecutive addresses starting at 2. There is one write per `rx_valid` cycle, and cycles without `rx_valid` change nothing.
- R6: `rx_err` high in any busy cycle, even together with `rx_valid`, writes nothing and ends the attempt with `err_code` 2 (receive fault).
- R7: Success is reported only after the final checksum byte: `done` and `ok` are high, with `err_code` 0, in the cycle after that byte's clock edge.
- R8: `done` is high for exactly one cycle. `busy` is then low, and `ok` and `err_code` keep their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Arm request, honoured only while idle |
| rx_valid | input | 1 | A received byte is present on rx_data |
| rx_data | input | DATA_W | Received byte |
| rx_err | input | 1 | Byte receiver reports a timeout or framing fault |
| own_addr | input | DATA_W | This node's address |
| max_len | input | DATA_W | Payload length limit; lengths at or above it are rejected |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | ADDR_W | Buffer write address |
| wr_data | output | DATA_W | Buffer write data |
| busy | output | 1 | An attempt is in progress |
| done | output | 1 | One-cycle end-of-attempt pulse |
| ok | output | 1 | Last attempt succeeded (held) |
| err_code | output | 2 | 0 ok, 1 not addressed here, 2 receive fault, 3 length error (held) |

## Verification
A control state that is wrong shows up on `wr_en` in the same cycle as the offending byte. A rejected address would be written, or a valid length would be dropped, and the bench compares every byte's strobe, address and data while that byte is on the input. A wrong remaining-byte count shifts the `done` pulse by at least one cycle away from the final checksum byte, which is caught at the first sample after the end of the packet. A result code that is lost or overwritten appears either at the `done` sample or one idle cycle later.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic [1:0] {
    RXF_OK       = 2'd0,
    RXF_NOT_MINE = 2'd1,
    RXF_IO       = 2'd2,
    RXF_DATA     = 2'd3
  } rxf_code_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DEST = 2'd1,
    ST_LEN  = 2'd2,
    ST_BODY = 2'd3
  } rxf_state_e;
endpackage

// File: rtl/rxf_addr_filter.sv
module rxf_addr_filter #(
  parameter int DATA_W      = 8,
  parameter bit ADDR_FILTER = 1'b1
) (
  input  logic [DATA_W-1:0] dest,
  input  logic [DATA_W-1:0] own,
  output logic              accept
);
  localparam logic [DATA_W-1:0] BCAST = {DATA_W{1'b1}};

  function automatic logic dest_ok(input logic [DATA_W-1:0] d, input logic [DATA_W-1:0] o);
    return (d == o) || (d == BCAST);
  endfunction

  generate
    if (ADDR_FILTER) begin : g_filter
      assign accept = dest_ok(dest, own);
    end else begin : g_open
      assign accept = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/rxf_counters.sv
module rxf_counters #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr_step,
  input  logic              load_len,
  input  logic [DATA_W-1:0] len_in,
  input  logic              body_step,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              last_body
);
  localparam int REM_W = DATA_W + 1;

  // payload plus one checksum byte
  function automatic logic [REM_W-1:0] body_total(input logic [DATA_W-1:0] len);
    return {1'b0, len} + REM_W'(1);
  endfunction

  logic [REM_W-1:0] remaining;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr   <= '0;
      remaining <= '0;
    end else begin
      if (clear)        wr_addr <= '0;
      else if (wr_step) wr_addr <= wr_addr + ADDR_W'(1);
      if (load_len)       remaining <= body_total(len_in);
      else if (body_step) remaining <= remaining - REM_W'(1);
    end
  end

  assign last_body = (remaining == REM_W'(1));
endmodule

// File: rtl/rx_packet_framer.sv
module rx_packet_framer
  import rxf_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 9,
  parameter bit ADDR_FILTER = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_err,
  input  logic [DATA_W-1:0] own_addr,
  input  logic [DATA_W-1:0] max_len,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              done,
  output logic              ok,
  output logic [1:0]        err_code
);
  rxf_state_e state;
  rxf_code_e  code_q;

  logic accept, byte_ok, last_body, arm;
  logic fin_io, fin_nm, fin_data, fin_ok, fin_any;
  logic len_bad;

  rxf_addr_filter #(.DATA_W(DATA_W), .ADDR_FILTER(ADDR_FILTER)) u_filter (
    .dest   (rx_data),
    .own    (own_addr),
    .accept (accept)
  );

  assign byte_ok  = rx_valid && !rx_err;
  assign arm      = (state == ST_IDLE) && start;
  assign len_bad  = (rx_data >= max_len);
  assign fin_io   = (state != ST_IDLE) && rx_err;
  assign fin_nm   = (state == ST_DEST) && byte_ok && !accept;
  assign fin_data = (state == ST_LEN)  && byte_ok && len_bad;
  assign fin_ok   = (state == ST_BODY) && byte_ok && last_body;
  assign fin_any  = fin_io || fin_nm || fin_data || fin_ok;

  assign wr_en   = byte_ok && (((state == ST_DEST) && accept) ||
                               (state == ST_LEN) || (state == ST_BODY));
  assign wr_data = rx_data;

  rxf_counters #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (arm),
    .wr_step   (wr_en),
    .load_len  ((state == ST_LEN) && byte_ok),
    .len_in    (rx_data),
    .body_step ((state == ST_BODY) && byte_ok),
    .wr_addr   (wr_addr),
    .last_body (last_body)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      code_q <= RXF_OK;
      done   <= 1'b0;
      ok     <= 1'b0;
    end else begin
      done <= fin_any;
      if (arm) begin
        state  <= ST_DEST;
        code_q <= RXF_OK;
        ok     <= 1'b0;
      end else if (fin_io) begin
        state  <= ST_IDLE;
        code_q <= RXF_IO;
      end else if (fin_nm) begin
        state  <= ST_IDLE;
        code_q <= RXF_NOT_MINE;
      end else if (fin_data) begin
        state  <= ST_IDLE;
        code_q <= RXF_DATA;
      end else if (fin_ok) begin
        state <= ST_IDLE;
        ok    <= 1'b1;
      end else if (byte_ok) begin
        case (state)
          ST_DEST: state <= ST_LEN;
          ST_LEN:  state <= ST_BODY;
          default: state <= state;
        endcase
      end
    end
  end

  assign busy     = (state != ST_IDLE);
  assign err_code = code_q;
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              busy,
  input logic              done,
  input logic              ok,
  input logic [1:0]        err_code
);
  assert_arm_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && wr_addr == '0 && err_code == 2'd0 && !ok));

  assert_write_only_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy);

  assert_addr_steps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (wr_addr == $past(wr_addr) + ADDR_W'(1)));

  assert_ok_means_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> (err_code == 2'd0));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_result_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(err_code) && $stable(ok)));
endmodule

bind rx_packet_framer rxf_checker #(.ADDR_W(ADDR_W)) u_rxf_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .busy     (busy),
  .done     (done),
  .ok       (ok),
  .err_code (err_code)
);

// File: tb/rx_packet_framer_test.sv
module rx_packet_framer_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] OWN = 8'h42;
  localparam logic [7:0] MAXL = 8'd20;
  localparam logic [7:0] NOFAULT = 8'hFF;

  // fields: [31:24] dest, [23:16] length, [15:8] fault position, [4] idle gaps, [1:0] expected code
  localparam int NV = 9;
  localparam logic [31:0] VEC [NV] = '{
    32'h42_03_FF_00, 32'hFF_05_FF_10, 32'h17_03_FF_01,
    32'h42_14_FF_03, 32'h42_13_FF_10, 32'h42_04_03_02,
    32'h42_02_00_02, 32'h42_00_FF_00, 32'h42_06_08_12
  };

  logic clk = 0, rst_n = 0, start = 0, start_any = 0;
  logic rx_valid = 0, rx_err = 0;
  logic [7:0] rx_data = 0;
  logic wr_en, busy, done, ok;
  logic [8:0] wr_addr;
  logic [7:0] wr_data;
  logic [1:0] err_code;
  logic a_wr_en, a_busy, a_done, a_ok;
  logic [8:0] a_wr_addr;
  logic [7:0] a_wr_data;
  logic [1:0] a_err;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_packet_framer uut (
    .clk(clk), .rst_n(rst_n), .start(start), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_err(rx_err), .own_addr(OWN), .max_len(MAXL), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .done(done), .ok(ok), .err_code(err_code));

  rx_packet_framer #(.ADDR_FILTER(1'b0)) uut_any (
    .clk(clk), .rst_n(rst_n), .start(start_any), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_err(rx_err), .own_addr(OWN), .max_len(MAXL), .wr_en(a_wr_en), .wr_addr(a_wr_addr),
    .wr_data(a_wr_data), .busy(a_busy), .done(a_done), .ok(a_ok), .err_code(a_err));

  task automatic check(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pay(input int p);
    return 8'(p * 29) ^ 8'hA5;
  endfunction

  task automatic pulse_start();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic send(input logic [7:0] b, input bit fault);
    @(negedge clk);
    rx_valid = 1; rx_err = fault; rx_data = b;
  endtask

  task automatic release_rx();
    @(negedge clk);
    rx_valid = 0; rx_err = 0;
  endtask

  task automatic run_vec(input logic [31:0] v);
    logic [7:0] dest, len, fpos;
    logic [1:0] exp;
    bit gaps;
    int n;
    dest = v[31:24]; len = v[23:16]; fpos = v[15:8]; gaps = v[4]; exp = v[1:0];
    case (exp)
      2'd1: n = 1;
      2'd3: n = 2;
      2'd2: n = fpos + 1;
      default: n = len + 3;
    endcase
    pulse_start();
    check(busy == 1'b1, "R1 busy after start", busy, 1);
    for (int p = 0; p < n; p++) begin
      logic [7:0] b;
      bit expw;
      b = (p == 0) ? dest : (p == 1) ? len : pay(p);
      send(b, p == fpos);
      #1;
      expw = (p != fpos) && !(p == 0 && exp == 2'd1);
      check(wr_en == expw, (p == fpos) ? "R6 no write on fault" : (p == 0) ? "R2 address write" :
            (p == 1) ? "R4 length write" : "R5 body write", wr_en, expw);
      if (expw) begin
        check(wr_addr == 9'(p) && wr_data == b, "R5 write address/data",
              {wr_addr, wr_data}, {9'(p), b});
      end
      if (gaps && p < n - 1) begin
        release_rx();
        #1 check(wr_en == 1'b0 && done == 1'b0, "R5 idle gap no write", wr_en, 0);
      end
    end
    release_rx();
    check(done == 1'b1, "R7 done after last byte", done, 1);
    check(err_code == exp, exp == 2'd0 ? "R7 code" : exp == 2'd1 ? "R2 code" :
          exp == 2'd2 ? "R6 code" : "R4 code", err_code, exp);
    check(ok == (exp == 2'd0) && busy == 1'b0, "R7 ok flag", ok, exp == 2'd0);
    @(negedge clk);
    check(done == 1'b0, "R8 done one cycle", done, 0);
    check(err_code == exp && ok == (exp == 2'd0), "R8 result held", err_code, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && ok == 0 && err_code == 0 && wr_en == 0,
          "R1 reset state", {busy, done, ok, err_code}, 0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R1: start while busy is ignored
    pulse_start();
    send(OWN, 0); release_rx();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    send(8'd1, 0); #1;
    check(wr_en && wr_addr == 9'd1, "R1 start ignored while busy", wr_addr, 1);
    send(8'h11, 0); send(8'h22, 0); #1;
    check(wr_addr == 9'd3, "R1 address continues", wr_addr, 3);
    release_rx();
    check(done && ok, "R1 packet completes", {done, ok}, 3);

    // R3: filtering disabled accepts a foreign address
    @(negedge clk) start_any = 1;
    @(negedge clk) start_any = 0;
    send(8'h17, 0); #1;
    check(a_wr_en && a_wr_addr == 0 && a_wr_data == 8'h17, "R3 foreign address stored",
          {a_wr_en, a_wr_addr}, {1'b1, 9'd0});
    check(wr_en == 1'b0, "R3 idle filtered unit writes nothing", wr_en, 0);
    send(8'd0, 0); send(8'h5A, 0);
    release_rx();
    check(a_done && a_ok && a_err == 0, "R3 open unit success", {a_done, a_ok, a_err}, 12);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule